// File: doc/BRIEF.md
# Hinted Instruction Prefetch Engine

This block sits beside the instruction fetch path and turns compiler prefetch hints into line fetches from the second-level cache. A hint arrives as a hinted instruction passes the decode stage. It carries a target line address and a mode bit. In burst mode the engine walks a fixed run of consecutive lines starting at the target. In stream mode it keeps walking successive lines until the front end reports a taken branch. All addresses on the ports are 32-byte line addresses, that is, byte address divided by 32.

Each candidate line is shown on a probe port that is checked against the instruction cache tags and the translation buffer. A candidate that the probe reports as present is skipped. A candidate that already sits in the streaming buffer, either filled or still awaited, is also skipped. Every other candidate goes to the second-level cache as one request. Returned lines are stored in an eight-entry streaming buffer. The fetch unit looks lines up there. A hit hands the line over and frees its entry.

Top module: `ifetch_prefetcher`

## Requirements
- R1: After reset the engine is idle. `probe_valid` and `l2_req_valid` are low and every lookup misses.
- R2: A hint with `hint_stream`=0 (burst) considers exactly the two lines `hint_line` and `hint_line`+1, one per cycle starting the cycle after the hint, and then goes idle.
- R3: A hint with `hint_stream`=1 considers `hint_line`, `hint_line`+1, ... one per cycle until `taken_valid` is seen. No request is issued in the cycle of `taken_valid` or after it.
- R4: A candidate for which `probe_hit` is high in its cycle is never requested. The engine moves to the next line in the following cycle. Every request has `probe_valid` high with `probe_line` equal to `l2_req_line`.
- R5: A line that is awaited or filled in the streaming buffer is not requested again.
- R6: A new hint abandons the current walk, in either mode, and restarts at the new target. No request is issued in the cycle the hint arrives.
- R7: While `l2_req_ready` is low, the pending request stays valid on the same line and the engine does not advance.
- R8: A response whose `l2_rsp_line` matches an awaited entry fills it. A later lookup of that line has `lookup_hit` high and returns the filled data in the same cycle.
- R9: A lookup hit frees the entry, so a lookup of the same line in the next cycle misses.
- R10: Each request takes the next buffer entry in round-robin order, replacing whatever it held. After nine requests, the line of the first is gone. The engine stalls if the next entry is still awaiting its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hint_valid | input | 1 | Prefetch hint seen at decode this cycle |
| hint_line | input | 27 | Target line address of the hint |
| hint_stream | input | 1 | 1 = stream mode, 0 = burst mode |
| taken_valid | input | 1 | Taken branch reported; ends a stream |
| probe_valid | output | 1 | Candidate line shown to the tag probe |
| probe_line | output | 27 | Candidate line address |
| probe_hit | input | 1 | Candidate already in instruction cache (same cycle) |
| l2_req_valid | output | 1 | Line request to second-level cache |
| l2_req_line | output | 27 | Requested line address |
| l2_req_ready | input | 1 | Second-level cache accepts the request |
| l2_rsp_valid | input | 1 | Returned line valid |
| l2_rsp_line | input | 27 | Line address of returned data |
| l2_rsp_data | input | 256 | Returned 32-byte line |
| lookup_valid | input | 1 | Fetch lookup in streaming buffer |
| lookup_line | input | 27 | Line address looked up |
| lookup_hit | output | 1 | Line found filled in the buffer |
| lookup_data | output | 256 | Line data on a hit |

## Verification
A hint can land in the same cycle that the sequencer would otherwise issue a request, or end a stream. The hint must win: nothing is issued that cycle, and the walk restarts at the new target. The bench provokes this directly by sending a burst hint two cycles into a stream, and it checks that the request log holds only the first two stream lines followed by the burst lines. It also provokes it at random by driving hints, taken branches and ready gaps against a free-running responder. Every accepted request is judged against the probe model, and every lookup hit is judged against the data each line should carry.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_PEND = 2'd1,
        SLOT_FULL = 2'd2
    } slot_state_e;
endpackage

// File: rtl/pfq_seq.sv
module pfq_seq #(
    parameter int LINE_AW     = 27,
    parameter int BURST_LINES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hint_valid,
    input  logic [LINE_AW-1:0] hint_line,
    input  logic               hint_stream,
    input  logic               taken_valid,
    input  logic               probe_hit,
    input  logic               buf_present,
    input  logic               slot_free,
    input  logic               req_ready,
    output logic               cand_valid,
    output logic [LINE_AW-1:0] cand_line,
    output logic               req_valid
);
    localparam int CNT_W = $clog2(BURST_LINES + 1);

    typedef struct packed {
        logic               active;
        logic               stream;
        logic [LINE_AW-1:0] line;
        logic [CNT_W-1:0]   left;
    } seq_t;

    seq_t s_d, s_q;
    logic kill, skip, step;

    always_comb begin
        kill      = hint_valid | (taken_valid & s_q.stream);
        skip      = probe_hit | buf_present;
        req_valid = s_q.active & ~kill & ~skip & slot_free;
        step      = s_q.active & ~kill & (skip | (req_valid & req_ready));
        cand_valid = s_q.active;
        cand_line  = s_q.line;

        s_d = s_q;
        if (hint_valid) begin
            s_d.active = 1'b1;
            s_d.stream = hint_stream;
            s_d.line   = hint_line;
            s_d.left   = CNT_W'(BURST_LINES);
        end else if (taken_valid && s_q.stream) begin
            s_d.active = 1'b0;
        end else if (step) begin
            s_d.line = s_q.line + 1'b1;
            if (!s_q.stream) begin
                s_d.left = s_q.left - 1'b1;
                if (s_q.left == CNT_W'(1)) begin
                    s_d.active = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/pfq_sbuf.sv
module pfq_sbuf #(
    parameter int LINE_AW   = 27,
    parameter int LINE_BITS = 256,
    parameter int DEPTH     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LINE_AW-1:0]   chk_line,
    output logic                 chk_present,
    output logic                 slot_free,
    input  logic                 alloc,
    input  logic [LINE_AW-1:0]   alloc_line,
    input  logic                 fill_valid,
    input  logic [LINE_AW-1:0]   fill_line,
    input  logic [LINE_BITS-1:0] fill_data,
    input  logic                 lk_valid,
    input  logic [LINE_AW-1:0]   lk_line,
    output logic                 lk_hit,
    output logic [LINE_BITS-1:0] lk_data
);
    import pfq_pkg::*;

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        slot_state_e [DEPTH-1:0]                st;
        logic        [DEPTH-1:0][LINE_AW-1:0]   tag;
        logic        [DEPTH-1:0][LINE_BITS-1:0] data;
        logic        [PTR_W-1:0]                rr;
    } sbuf_t;

    sbuf_t b_d, b_q;

    logic [DEPTH-1:0] m_chk, m_fill, m_lk;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign m_chk[g]  = (b_q.st[g] != SLOT_FREE) && (b_q.tag[g] == chk_line);
        assign m_fill[g] = fill_valid && (b_q.st[g] == SLOT_PEND) && (b_q.tag[g] == fill_line);
        assign m_lk[g]   = lk_valid && (b_q.st[g] == SLOT_FULL) && (b_q.tag[g] == lk_line);
    end

    always_comb begin
        chk_present = |m_chk;
        slot_free   = (b_q.st[b_q.rr] != SLOT_PEND);
        lk_hit      = |m_lk;
        lk_data     = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (m_lk[i]) begin
                lk_data = lk_data | b_q.data[i];
            end
        end

        b_d = b_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (m_lk[i]) begin
                b_d.st[i] = SLOT_FREE;
            end
            if (m_fill[i]) begin
                b_d.st[i]   = SLOT_FULL;
                b_d.data[i] = fill_data;
            end
        end
        if (alloc) begin
            b_d.st[b_q.rr]  = SLOT_PEND;
            b_d.tag[b_q.rr] = alloc_line;
            b_d.rr          = (b_q.rr == LAST) ? '0 : b_q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end
endmodule

// File: rtl/ifetch_prefetcher.sv
module ifetch_prefetcher #(
    parameter int LINE_AW     = 27,
    parameter int LINE_BITS   = 256,
    parameter int DEPTH       = 8,
    parameter int BURST_LINES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hint_valid,
    input  logic [LINE_AW-1:0]   hint_line,
    input  logic                 hint_stream,
    input  logic                 taken_valid,
    output logic                 probe_valid,
    output logic [LINE_AW-1:0]   probe_line,
    input  logic                 probe_hit,
    output logic                 l2_req_valid,
    output logic [LINE_AW-1:0]   l2_req_line,
    input  logic                 l2_req_ready,
    input  logic                 l2_rsp_valid,
    input  logic [LINE_AW-1:0]   l2_rsp_line,
    input  logic [LINE_BITS-1:0] l2_rsp_data,
    input  logic                 lookup_valid,
    input  logic [LINE_AW-1:0]   lookup_line,
    output logic                 lookup_hit,
    output logic [LINE_BITS-1:0] lookup_data
);
    logic               cand_valid;
    logic [LINE_AW-1:0] cand_line;
    logic               buf_present;
    logic               slot_free;
    logic               req_valid;
    logic               issue;

    assign issue        = req_valid & l2_req_ready;
    assign probe_valid  = cand_valid;
    assign probe_line   = cand_line;
    assign l2_req_valid = req_valid;
    assign l2_req_line  = cand_line;

    pfq_seq #(
        .LINE_AW     (LINE_AW),
        .BURST_LINES (BURST_LINES)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .hint_valid  (hint_valid),
        .hint_line   (hint_line),
        .hint_stream (hint_stream),
        .taken_valid (taken_valid),
        .probe_hit   (probe_hit),
        .buf_present (buf_present),
        .slot_free   (slot_free),
        .req_ready   (l2_req_ready),
        .cand_valid  (cand_valid),
        .cand_line   (cand_line),
        .req_valid   (req_valid)
    );

    pfq_sbuf #(
        .LINE_AW   (LINE_AW),
        .LINE_BITS (LINE_BITS),
        .DEPTH     (DEPTH)
    ) i_sbuf (
        .clk         (clk),
        .rst_n       (rst_n),
        .chk_line    (cand_line),
        .chk_present (buf_present),
        .slot_free   (slot_free),
        .alloc       (issue),
        .alloc_line  (cand_line),
        .fill_valid  (l2_rsp_valid),
        .fill_line   (l2_rsp_line),
        .fill_data   (l2_rsp_data),
        .lk_valid    (lookup_valid),
        .lk_line     (lookup_line),
        .lk_hit      (lookup_hit),
        .lk_data     (lookup_data)
    );
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
    parameter int LINE_AW = 27
) (
    input logic               clk,
    input logic               rst_n,
    input logic               hint_valid,
    input logic [LINE_AW-1:0] hint_line,
    input logic               taken_valid,
    input logic               probe_valid,
    input logic [LINE_AW-1:0] probe_line,
    input logic               probe_hit,
    input logic               l2_req_valid,
    input logic [LINE_AW-1:0] l2_req_line,
    input logic               l2_req_ready,
    input logic               lookup_valid,
    input logic [LINE_AW-1:0] lookup_line,
    input logic               lookup_hit
);
    AST_REQ_NOT_PROBE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        l2_req_valid |-> !probe_hit); // R4
    AST_REQ_MATCHES_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
        l2_req_valid |-> (probe_valid && probe_line == l2_req_line)); // R4
    AST_HINT_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        hint_valid |-> !l2_req_valid); // R6
    AST_HINT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        hint_valid |=> (probe_valid && probe_line == $past(hint_line))); // R6
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_req_valid && !l2_req_ready && !hint_valid && !taken_valid)
        |=> (probe_valid && $stable(probe_line))); // R7
    AST_ISSUE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_req_valid && l2_req_ready && !hint_valid)
        |=> (!probe_valid || probe_line == $past(l2_req_line) + 1'b1)); // R2
    AST_NO_REPEAT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_req_valid && l2_req_ready)
        |=> !(l2_req_valid && l2_req_line == $past(l2_req_line))); // R5
    AST_LOOKUP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid && lookup_hit)
        |=> !(lookup_valid && lookup_hit && lookup_line == $past(lookup_line))); // R9
endmodule

bind ifetch_prefetcher pfq_checker #(.LINE_AW(LINE_AW)) i_pfq_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .hint_valid   (hint_valid),
    .hint_line    (hint_line),
    .taken_valid  (taken_valid),
    .probe_valid  (probe_valid),
    .probe_line   (probe_line),
    .probe_hit    (probe_hit),
    .l2_req_valid (l2_req_valid),
    .l2_req_line  (l2_req_line),
    .l2_req_ready (l2_req_ready),
    .lookup_valid (lookup_valid),
    .lookup_line  (lookup_line),
    .lookup_hit   (lookup_hit)
);

// File: tb/test_ifetch_prefetcher.sv
module test_ifetch_prefetcher;
    localparam int CLK_NS = 10;
    localparam int AW = 27;
    localparam int DW = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hint_valid = 1'b0;
    logic [AW-1:0] hint_line = '0;
    logic          hint_stream = 1'b0;
    logic          taken_valid = 1'b0;
    logic          probe_valid;
    logic [AW-1:0] probe_line;
    logic          probe_hit;
    logic          l2_req_valid;
    logic [AW-1:0] l2_req_line;
    logic          l2_req_ready = 1'b1;
    logic          l2_rsp_valid = 1'b0;
    logic [AW-1:0] l2_rsp_line = '0;
    logic [DW-1:0] l2_rsp_data = '0;
    logic          lookup_valid = 1'b0;
    logic [AW-1:0] lookup_line = '0;
    logic          lookup_hit;
    logic [DW-1:0] lookup_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [AW-1:0] req_log [256];
    int            log_n = 0;
    logic          pipe_v = 1'b0;
    logic [AW-1:0] pipe_l = '0;

    always #(CLK_NS/2) clk = ~clk;

    function automatic bit icache_has(logic [AW-1:0] l);
        return (l % 5) == 3;
    endfunction

    function automatic logic [DW-1:0] line_data(logic [AW-1:0] l);
        logic [31:0] w;
        w = {5'd0, l} * 32'h9E3779B9 + 32'h01234567;
        return {8{w}};
    endfunction

    assign probe_hit = probe_valid && icache_has(probe_line);

    ifetch_prefetcher i_ifetch_prefetcher (
        .clk(clk), .rst_n(rst_n),
        .hint_valid(hint_valid), .hint_line(hint_line), .hint_stream(hint_stream),
        .taken_valid(taken_valid),
        .probe_valid(probe_valid), .probe_line(probe_line), .probe_hit(probe_hit),
        .l2_req_valid(l2_req_valid), .l2_req_line(l2_req_line), .l2_req_ready(l2_req_ready),
        .l2_rsp_valid(l2_rsp_valid), .l2_rsp_line(l2_rsp_line), .l2_rsp_data(l2_rsp_data),
        .lookup_valid(lookup_valid), .lookup_line(lookup_line),
        .lookup_hit(lookup_hit), .lookup_data(lookup_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor and second-level cache model, one cycle of latency after acceptance
    always @(negedge clk) begin
        if (rst_n) begin
            if (lookup_valid && lookup_hit)
                chk(lookup_data == line_data(lookup_line), "R8 lookup data",
                    lookup_data[63:0], line_data(lookup_line) >> 0);
            if (l2_req_valid && l2_req_ready) begin
                chk(!icache_has(l2_req_line), "R4 request of cached line", 64'(l2_req_line), 64'd0);
                chk(!(pipe_v && pipe_l == l2_req_line), "R5 duplicate outstanding",
                    64'(l2_req_line), 64'(pipe_l));
                req_log[log_n % 256] = l2_req_line;
                log_n++;
            end
            l2_rsp_valid <= pipe_v;
            l2_rsp_line  <= pipe_l;
            l2_rsp_data  <= line_data(pipe_l);
            pipe_v       <= l2_req_valid && l2_req_ready;
            pipe_l       <= l2_req_line;
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) cyc();
    endtask

    task automatic hint(input logic [AW-1:0] l, input bit stream);
        hint_valid  = 1'b1;
        hint_line   = l;
        hint_stream = stream;
        cyc();
        hint_valid  = 1'b0;
    endtask

    task automatic taken_pulse();
        taken_valid = 1'b1;
        cyc();
        taken_valid = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        int exp_n;
        void'($urandom(32'd2024));
        idle(3);
        rst_n = 1'b1;
        cyc();

        // R1: idle after reset, buffer empty
        chk(probe_valid == 1'b0, "R1 probe idle", 64'(probe_valid), 64'd0);
        chk(l2_req_valid == 1'b0, "R1 request idle", 64'(l2_req_valid), 64'd0);
        lookup_valid = 1'b1; lookup_line = 27'd5; #1;
        chk(lookup_hit == 1'b0, "R1 empty buffer", 64'(lookup_hit), 64'd0);
        lookup_valid = 1'b0;
        cyc();

        // R2: burst covers two lines then idles
        base = log_n;
        hint(27'd100, 1'b0);
        idle(6);
        chk(log_n - base == 2, "R2 burst count", 64'(log_n - base), 64'd2);
        chk(req_log[base % 256] == 27'd100, "R2 first line", 64'(req_log[base % 256]), 64'd100);
        chk(req_log[(base+1) % 256] == 27'd101, "R2 second line", 64'(req_log[(base+1) % 256]), 64'd101);
        chk(probe_valid == 1'b0, "R2 idle after burst", 64'(probe_valid), 64'd0);

        // R8 then R9: lookup returns data and frees entry
        lookup_valid = 1'b1; lookup_line = 27'd100; #1;
        chk(lookup_hit == 1'b1, "R8 lookup hit", 64'(lookup_hit), 64'd1);
        chk(lookup_data == line_data(27'd100), "R8 data", lookup_data[63:0], line_data(27'd100) >> 0);
        cyc();
        chk(lookup_hit == 1'b0, "R9 freed entry", 64'(lookup_hit), 64'd0);
        lookup_valid = 1'b0;

        // R4: cached target skipped
        base = log_n;
        hint(27'd103, 1'b0);
        idle(6);
        chk(log_n - base == 1, "R4 filtered count", 64'(log_n - base), 64'd1);
        chk(req_log[base % 256] == 27'd104, "R4 next line", 64'(req_log[base % 256]), 64'd104);

        // R5: line already in buffer not requested
        base = log_n;
        hint(27'd101, 1'b0);
        idle(6);
        chk(log_n - base == 1, "R5 dedup count", 64'(log_n - base), 64'd1);
        chk(req_log[base % 256] == 27'd102, "R5 new line only", 64'(req_log[base % 256]), 64'd102);

        // R3: stream until taken
        base = log_n;
        hint(27'd200, 1'b1);
        idle(6);
        taken_pulse();
        idle(10);
        exp_n = 0;
        for (int l = 200; l < 206; l++) begin
            if (!icache_has(AW'(l))) begin
                chk(req_log[(base + exp_n) % 256] == AW'(l), "R3 stream line",
                    64'(req_log[(base + exp_n) % 256]), 64'(l));
                exp_n++;
            end
        end
        chk(log_n - base == exp_n, "R3 stream stopped", 64'(log_n - base), 64'(exp_n));
        chk(probe_valid == 1'b0, "R3 idle after taken", 64'(probe_valid), 64'd0);

        // R6: new hint overrides a running stream
        base = log_n;
        hint(27'd300, 1'b1);
        idle(2);
        hint(27'd400, 1'b0);
        idle(6);
        chk(log_n - base == 4, "R6 restart count", 64'(log_n - base), 64'd4);
        chk(req_log[(base+1) % 256] == 27'd301, "R6 before restart", 64'(req_log[(base+1) % 256]), 64'd301);
        chk(req_log[(base+2) % 256] == 27'd400, "R6 new target", 64'(req_log[(base+2) % 256]), 64'd400);
        chk(req_log[(base+3) % 256] == 27'd401, "R6 new target next", 64'(req_log[(base+3) % 256]), 64'd401);

        // R7: back-pressure holds the request
        base = log_n;
        l2_req_ready = 1'b0;
        hint(27'd500, 1'b0);
        idle(3);
        chk(l2_req_valid == 1'b1, "R7 held valid", 64'(l2_req_valid), 64'd1);
        chk(l2_req_line == 27'd500, "R7 held line", 64'(l2_req_line), 64'd500);
        chk(log_n == base, "R7 nothing accepted", 64'(log_n - base), 64'd0);
        l2_req_ready = 1'b1;
        idle(5);
        chk(log_n - base == 2, "R7 resumes", 64'(log_n - base), 64'd2);

        // R10: ninth allocation replaces the first
        base = log_n;
        hint(27'd600, 1'b1);
        idle(11);
        taken_pulse();
        idle(5);
        chk(log_n - base == 9, "R10 nine requests", 64'(log_n - base), 64'd9);
        lookup_valid = 1'b1; lookup_line = 27'd600; #1;
        chk(lookup_hit == 1'b0, "R10 oldest replaced", 64'(lookup_hit), 64'd0);
        lookup_line = 27'd601; #1;
        chk(lookup_hit == 1'b1, "R10 second kept", 64'(lookup_hit), 64'd1);
        lookup_valid = 1'b0;
        cyc();

        // Random mix: R4, R5, R8 checked by the monitor
        base = log_n;
        for (int i = 0; i < 3000; i++) begin
            hint_valid   = ($urandom % 12) == 0;
            hint_line    = AW'($urandom % 48);
            hint_stream  = $urandom % 2;
            taken_valid  = ($urandom % 16) == 0;
            l2_req_ready = ($urandom % 4) != 0;
            lookup_valid = $urandom % 2;
            lookup_line  = AW'($urandom % 56);
            cyc();
        end
        hint_valid = 1'b0; taken_valid = 1'b0; lookup_valid = 1'b0; l2_req_ready = 1'b1;
        idle(5);
        chk(log_n > base, "R3 random traffic issued", 64'(log_n - base), 64'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule